// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

The block controls a 32-pin general-purpose I/O port. Each pin either acts as plain software-driven I/O or hands its pad to one of up to three peripheral functions. A small register bus with 32-bit and 16-bit accesses configures the per-pin function select, direction and pull-up disable. The same bus drives an output latch through four data registers: a direct write, bit set, bit clear and bit toggle.

The function-select, direction and pull-up-disable registers are guarded by a protection-enable input. A change of function select reaches the pads a fixed two cycles after the write. The latch registers can be written at any time. Pad inputs pass through a two-flop synchronizer before they reach the data register read path and the peripheral inputs. Peripheral signals connect through plain flattened ports, with function `k` (1..3) of pin `p` at bit `(k-1)*32+p`.

Bus addresses count 16-bit half-words. Each 32-bit register occupies an even address. Address bit 0 selects the upper half for 16-bit accesses and is ignored for 32-bit accesses.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, every function select code and every direction bit is 0, the latch is 0, and all pull-ups are enabled. As a result, `pad_oe_o`=0, `pad_out_o`=0, `pad_pu_o`=all ones and `periph_in_o`=0.
- R2: Function select for pins 0..15 lives at address 0x0 and for pins 16..31 at address 0x2, with two bits per pin in ascending order. Pin p uses bits [2(p%16)+1 : 2(p%16)]. Code 00 means GPIO and codes 01, 10 and 11 select functions 1, 2 and 3. Both registers read back as written.
- R3: A function select write sampled at clock edge E changes pad behaviour starting at edge E+2. The pads are unchanged after edge E+1.
- R4: A write to a protected register (function select 0x0/0x2, direction 0x4, pull-up disable 0x6) while `prot_en_i` is 0 is ignored. Readback and pad behaviour are unchanged.
- R5: The data (0x8), set (0xA), clear (0xC) and toggle (0xE) registers act whatever the value of `prot_en_i`.
- R6: On a set, clear or toggle write, each 1 bit sets, clears or inverts the matching latch bit, and each 0 bit leaves it unchanged. Reads of set, clear and toggle return 0.
- R7: A 16-bit access (`bus_wide_i`=0) uses `bus_wdata_i[15:0]` and touches only the half chosen by address bit 0 (1 = upper). A 16-bit read returns that half in bits [15:0] with bits [31:16] zero.
- R8: For a pin in GPIO mode, `pad_oe_o` equals its direction bit (1 = output) and `pad_out_o` equals its latch bit. A direction write is effective from the next clock edge. Direction reads back at 0x4.
- R9: For a pin whose selected function is available, `pad_oe_o` and `pad_out_o` follow that function's `periph_oe_i`/`periph_out_i` bit combinationally. Only that function's `periph_in_o` bit carries the synchronized pad input.
- R10: A selected function that is not available (reserved) leaves the pad undriven (`pad_oe_o`=0) and the function gets no input. The default availability masks are: function 1 on all pins, function 2 on pins with mask 0x00FF00FF, and function 3 on pins with mask 0x0F0F0F0F.
- R11: A read of the data register (0x8) returns `pad_in_i` delayed by two clock edges.
- R12: `pad_pu_o` is the inverse of the pull-up-disable register at 0x6, and that register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_en_i | input | 1 | Permits writes to protected registers |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr_i | input | 4 | Half-word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational from address) |
| pad_in_i | input | 32 | Pad input levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| pad_pu_o | output | 32 | Pad pull-up enables |
| periph_out_i | input | 96 | Peripheral output per function and pin |
| periph_oe_i | input | 96 | Peripheral output enable per function and pin |
| periph_in_o | output | 96 | Synchronized input routed to the selected function |

## Verification
The bench checks the select latency edge by edge. A design that applied the select one cycle early, or held it a cycle late, shows the wrong pad enable at one of the two sampled points. Writes with protection low are aimed at both the select and the direction registers: a missing gate alters readback or pad enables. Half-word accesses to the data, set and toggle registers check that a merge does not spill into the other half or zero it. A pin is set to a reserved code while its peripheral asserts output enable, which catches a design that drives the pad anyway. A pin in the upper select register checks that the field layout is not shifted.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned NUM_PINS = 32;
  localparam int unsigned NUM_FN   = 3;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned FSEL_W   = NUM_PINS * SEL_W;
  localparam int unsigned FN_VEC_W = NUM_PINS * NUM_FN;

  // word index = half-word address >> 1
  typedef enum logic [ADDR_W-2:0] {
    REG_FSEL_LO = 3'd0,
    REG_FSEL_HI = 3'd1,
    REG_DIR     = 3'd2,
    REG_PUDIS   = 3'd3,
    REG_DAT     = 3'd4,
    REG_SET     = 3'd5,
    REG_CLR     = 3'd6,
    REG_TGL     = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic fsel_lo;
    logic fsel_hi;
    logic dir;
    logic pudis;
    logic dat;
    logic bset;
    logic bclr;
    logic btgl;
  } reg_stb_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
(
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic                bus_wide_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  input  logic                prot_en_i,
  output reg_stb_t            wr_stb_o,
  output logic [NUM_PINS-1:0] wmask_o,
  output logic [NUM_PINS-1:0] wdata_o,
  output reg_idx_e            rd_idx_o,
  output logic                rd_hi_o
);
  logic we;
  logic wp;
  reg_idx_e idx;

  assign idx      = reg_idx_e'(bus_addr_i[ADDR_W-1:1]);
  assign rd_idx_o = idx;
  assign rd_hi_o  = bus_addr_i[0] & ~bus_wide_i;
  assign we       = bus_valid_i & bus_write_i;
  assign wp       = we & prot_en_i;

  assign wmask_o = bus_wide_i   ? '1 :
                   bus_addr_i[0] ? {{HALF_W{1'b1}}, {HALF_W{1'b0}}} :
                                   {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign wdata_o = bus_wide_i ? bus_wdata_i : {2{bus_wdata_i[HALF_W-1:0]}};

  always_comb begin
    wr_stb_o         = '0;
    wr_stb_o.fsel_lo = wp & (idx == REG_FSEL_LO);
    wr_stb_o.fsel_hi = wp & (idx == REG_FSEL_HI);
    wr_stb_o.dir     = wp & (idx == REG_DIR);
    wr_stb_o.pudis   = wp & (idx == REG_PUDIS);
    wr_stb_o.dat     = we & (idx == REG_DAT);
    wr_stb_o.bset    = we & (idx == REG_SET);
    wr_stb_o.bclr    = we & (idx == REG_CLR);
    wr_stb_o.btgl    = we & (idx == REG_TGL);
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  reg_stb_t            wr_stb_i,
  input  logic [NUM_PINS-1:0] wmask_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [FSEL_W-1:0]   fsel_q_o,
  output logic [FSEL_W-1:0]   fsel_eff_o,
  output logic [NUM_PINS-1:0] dir_q_o,
  output logic [NUM_PINS-1:0] pud_q_o
);
  logic [NUM_PINS-1:0] merged_lo, merged_hi, merged_dir, merged_pud;

  assign merged_lo  = (fsel_q_o[NUM_PINS-1:0] & ~wmask_i) | (wdata_i & wmask_i);
  assign merged_hi  = (fsel_q_o[FSEL_W-1:NUM_PINS] & ~wmask_i) | (wdata_i & wmask_i);
  assign merged_dir = (dir_q_o & ~wmask_i) | (wdata_i & wmask_i);
  assign merged_pud = (pud_q_o & ~wmask_i) | (wdata_i & wmask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q_o <= '0;
      dir_q_o  <= '0;
      pud_q_o  <= '0;
    end else begin
      if (wr_stb_i.fsel_lo) fsel_q_o[NUM_PINS-1:0]      <= merged_lo;
      if (wr_stb_i.fsel_hi) fsel_q_o[FSEL_W-1:NUM_PINS] <= merged_hi;
      if (wr_stb_i.dir)     dir_q_o                     <= merged_dir;
      if (wr_stb_i.pudis)   pud_q_o                     <= merged_pud;
    end
  end

  // delay line between the visible select and the one that steers the pads
  generate
    if (LAT == 0) begin : g_nolat
      assign fsel_eff_o = fsel_q_o;
    end else begin : g_lat
      logic [FSEL_W-1:0] pipe_q [LAT];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < int'(LAT); i++) pipe_q[i] <= '0;
        end else begin
          pipe_q[0] <= fsel_q_o;
          for (int i = 1; i < int'(LAT); i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign fsel_eff_o = pipe_q[LAT-1];
    end

    if (LAT == 2) begin : g_lat_chk
      // R3
      fsel_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fsel_eff_o) |-> (fsel_eff_o == $past(fsel_q_o, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  reg_stb_t            wr_stb_i,
  input  logic [NUM_PINS-1:0] wmask_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] latch_q_o
);
  logic [NUM_PINS-1:0] mbits;
  assign mbits = wdata_i & wmask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q_o <= '0;
    end else if (wr_stb_i.dat) begin
      latch_q_o <= (latch_q_o & ~wmask_i) | mbits;
    end else if (wr_stb_i.bset) begin
      latch_q_o <= latch_q_o | mbits;
    end else if (wr_stb_i.bclr) begin
      latch_q_o <= latch_q_o & ~mbits;
    end else if (wr_stb_i.btgl) begin
      latch_q_o <= latch_q_o ^ mbits;
    end
  end

  // R6
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i.bset |=> (((latch_q_o & $past(mbits)) == $past(mbits)) &&
                       ((latch_q_o & ~$past(mbits)) == ($past(latch_q_o) & ~$past(mbits)))));
  // R6
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i.bclr |=> (((latch_q_o & $past(mbits)) == '0) &&
                       ((latch_q_o & ~$past(mbits)) == ($past(latch_q_o) & ~$past(mbits)))));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter logic [FN_VEC_W-1:0] FN_AVAIL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FSEL_W-1:0]   fsel_eff_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] in_sync_i,
  input  logic [FN_VEC_W-1:0] periph_out_i,
  input  logic [FN_VEC_W-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [FN_VEC_W-1:0] periph_in_o
);
  generate
    for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
      logic [SEL_W-1:0]  sel;
      logic [NUM_FN-1:0] hit, f_oe, f_out, f_in;
      assign sel = fsel_eff_i[SEL_W*p +: SEL_W];

      for (genvar k = 0; k < int'(NUM_FN); k++) begin : g_fn
        localparam int unsigned IDX = k * NUM_PINS + p;
        assign hit[k]           = (sel == SEL_W'(k + 1)) & FN_AVAIL[IDX];
        assign f_oe[k]          = periph_oe_i[IDX];
        assign f_out[k]         = periph_out_i[IDX];
        assign periph_in_o[IDX] = in_sync_i[p] & hit[k];
        assign f_in[k]          = periph_in_o[IDX];
      end

      assign pad_oe_o[p]  = (sel == '0) ? dir_i[p]   : |(hit & f_oe);
      assign pad_out_o[p] = (sel == '0) ? latch_i[p] : |(hit & f_out);

      // R9
      fn_in_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(f_in));
    end
  endgenerate
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned         CFG_LAT  = 2,
  parameter logic [FN_VEC_W-1:0] FN_AVAIL = {32'h0F0F_0F0F, 32'h00FF_00FF, 32'hFFFF_FFFF}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prot_en_i,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic                bus_wide_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  input  logic [FN_VEC_W-1:0] periph_out_i,
  input  logic [FN_VEC_W-1:0] periph_oe_i,
  output logic [FN_VEC_W-1:0] periph_in_o
);
  reg_stb_t            wr_stb;
  logic [NUM_PINS-1:0] wmask, wdata;
  reg_idx_e            rd_idx;
  logic                rd_hi;
  logic [FSEL_W-1:0]   fsel_q, fsel_eff;
  logic [NUM_PINS-1:0] dir_q, pud_q, latch_q;
  logic [NUM_PINS-1:0] sync1_q, in_sync_q;
  logic [NUM_PINS-1:0] rd_word;
  logic [1:0]          rst_age_q;

  gpio_bus_decode u_dec (
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_wide_i  (bus_wide_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .prot_en_i   (prot_en_i),
    .wr_stb_o    (wr_stb),
    .wmask_o     (wmask),
    .wdata_o     (wdata),
    .rd_idx_o    (rd_idx),
    .rd_hi_o     (rd_hi)
  );

  gpio_cfg_regs #(.LAT(CFG_LAT)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb),
    .wmask_i    (wmask),
    .wdata_i    (wdata),
    .fsel_q_o   (fsel_q),
    .fsel_eff_o (fsel_eff),
    .dir_q_o    (dir_q),
    .pud_q_o    (pud_q)
  );

  gpio_out_latch u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wmask_i   (wmask),
    .wdata_i   (wdata),
    .latch_q_o (latch_q)
  );

  gpio_pin_mux #(.FN_AVAIL(FN_AVAIL)) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fsel_eff_i   (fsel_eff),
    .dir_i        (dir_q),
    .latch_i      (latch_q),
    .in_sync_i    (in_sync_q),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pad_oe_o     (pad_oe_o),
    .pad_out_o    (pad_out_o),
    .periph_in_o  (periph_in_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q   <= '0;
      in_sync_q <= '0;
      rst_age_q <= '0;
    end else begin
      sync1_q   <= pad_in_i;
      in_sync_q <= sync1_q;
      if (rst_age_q != 2'd3) rst_age_q <= rst_age_q + 2'd1;
    end
  end

  assign pad_pu_o = ~pud_q;

  always_comb begin
    case (rd_idx)
      REG_FSEL_LO: rd_word = fsel_q[NUM_PINS-1:0];
      REG_FSEL_HI: rd_word = fsel_q[FSEL_W-1:NUM_PINS];
      REG_DIR:     rd_word = dir_q;
      REG_PUDIS:   rd_word = pud_q;
      REG_DAT:     rd_word = in_sync_q;
      default:     rd_word = '0;
    endcase
  end

  assign bus_rdata_o = bus_wide_i ? rd_word :
                       {{HALF_W{1'b0}}, rd_hi ? rd_word[NUM_PINS-1:HALF_W] : rd_word[HALF_W-1:0]};

  // R4
  prot_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && !prot_en_i && !bus_addr_i[ADDR_W-1])
      |=> ($stable(fsel_q) && $stable(dir_q) && $stable(pud_q)));

  // R11
  in_sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_age_q == 2'd3) |-> (in_sync_q == $past(pad_in_i, 2)));
endmodule

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 23;

  // {wr, prot, wide, addr[3:0], data[31:0], exp[31:0]}; exp = rdata for reads, pad_out after writes
  localparam logic [70:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b1, 4'h4, 32'hA5A5_0F0F, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 4'h4, 32'h0,         32'hA5A5_0F0F},
    {1'b1, 1'b0, 1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 4'h4, 32'h0,         32'hA5A5_0F0F},
    {1'b1, 1'b1, 1'b0, 4'h5, 32'h0000_1234, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 4'h4, 32'h0,         32'h1234_0F0F},
    {1'b0, 1'b0, 1'b0, 4'h5, 32'h0,         32'h0000_1234},
    {1'b0, 1'b0, 1'b0, 4'h4, 32'h0,         32'h0000_0F0F},
    {1'b1, 1'b0, 1'b1, 4'h8, 32'h0000_00F0, 32'h0000_00F0},
    {1'b1, 1'b0, 1'b1, 4'hA, 32'h0000_0F00, 32'h0000_0FF0},
    {1'b1, 1'b0, 1'b1, 4'hC, 32'h0000_0030, 32'h0000_0FC0},
    {1'b1, 1'b0, 1'b1, 4'hE, 32'hFFFF_0000, 32'hFFFF_0FC0},
    {1'b1, 1'b1, 1'b0, 4'hF, 32'h0000_00FF, 32'hFF00_0FC0},
    {1'b1, 1'b1, 1'b0, 4'hA, 32'h0000_0001, 32'hFF00_0FC1},
    {1'b1, 1'b0, 1'b0, 4'h9, 32'h0000_ABCD, 32'hABCD_0FC1},
    {1'b0, 1'b0, 1'b1, 4'hA, 32'h0,         32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 4'hE, 32'h0,         32'h0000_0000},
    {1'b0, 1'b0, 1'b0, 4'hD, 32'h0,         32'h0000_0000},
    {1'b1, 1'b1, 1'b1, 4'h6, 32'h0000_FFFF, 32'hABCD_0FC1},
    {1'b0, 1'b0, 1'b1, 4'h6, 32'h0,         32'h0000_FFFF},
    {1'b1, 1'b1, 1'b1, 4'h2, 32'h8000_0001, 32'hABCD_0FC1},
    {1'b0, 1'b0, 1'b1, 4'h2, 32'h0,         32'h8000_0001},
    {1'b0, 1'b0, 1'b0, 4'h3, 32'h0,         32'h0000_8000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prot_en_i = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic        bus_wide_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] pad_in_i = '0;
  logic [31:0] pad_out_o, pad_oe_o, pad_pu_o;
  logic [95:0] periph_out_i = '0;
  logic [95:0] periph_oe_i = '0;
  logic [95:0] periph_in_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] rd;

  gpio_mux_port dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prot_en_i    (prot_en_i),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_wide_i   (bus_wide_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .pad_in_i     (pad_in_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o),
    .pad_pu_o     (pad_pu_o),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .periph_in_o  (periph_in_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic bus_wr(input logic prot, input logic wide, input logic [3:0] addr,
                        input logic [31:0] data);
    @(negedge clk_i);
    prot_en_i = prot; bus_valid_i = 1'b1; bus_write_i = 1'b1;
    bus_wide_i = wide; bus_addr_i = addr; bus_wdata_i = data;
    @(posedge clk_i);
    #1;
    bus_valid_i = 1'b0; bus_write_i = 1'b0; prot_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  // call at a falling edge
  task automatic bus_rd(input logic wide, input logic [3:0] addr, output logic [31:0] data);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_wide_i = wide; bus_addr_i = addr;
    #1;
    data = bus_rdata_o;
    bus_valid_i = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edges(1);

    // R1 reset state
    chk("R1 pad_oe", 96'(pad_oe_o), 96'h0);
    chk("R1 pad_out", 96'(pad_out_o), 96'h0);
    chk("R1 pad_pu", 96'(pad_pu_o), 96'hFFFF_FFFF);
    chk("R1 periph_in", periph_in_o, 96'h0);
    bus_rd(1'b1, 4'h0, rd); chk("R1 fsel_lo", 96'(rd), 96'h0);
    bus_rd(1'b1, 4'h4, rd); chk("R1 dir", 96'(rd), 96'h0);

    // vector table: R4 R5 R6 R7 R8 R12 R2 readback/latch
    for (int v = 0; v < NV; v++) begin
      logic [70:0] e;
      e = VECS[v];
      if (e[70]) begin
        bus_wr(e[69], e[68], e[67:64], e[63:32]);
        chk($sformatf("R5/R6/R7 vec%0d pad_out", v), 96'(pad_out_o), 96'(e[31:0]));
      end else begin
        @(negedge clk_i);
        bus_rd(e[68], e[67:64], rd);
        chk($sformatf("R2/R4/R6/R7/R8/R12 vec%0d rdata", v), 96'(rd), 96'(e[31:0]));
      end
    end

    bus_wr(1'b1, 1'b1, 4'h2, 32'h0);
    edges(2);
    // R12
    chk("R12 pad_pu", 96'(pad_pu_o), 96'hFFFF_0000);

    // R8 direction one cycle
    bus_wr(1'b1, 1'b1, 4'h4, 32'h0000_00FF);
    chk("R8 pad_oe", 96'(pad_oe_o), 96'h0000_00FF);
    chk("R8 pad_out", 96'(pad_out_o), 96'hABCD_0FC1);

    // R3 R9 R10: pin2 -> fn1, pin4 -> fn3 (reserved on pin4)
    bus_wr(1'b0, 1'b1, 4'h8, 32'h0);
    bus_wr(1'b1, 1'b1, 4'h4, 32'h0000_0010);
    periph_out_i[2] = 1'b1; periph_oe_i[2] = 1'b1;
    periph_out_i[68] = 1'b1; periph_oe_i[68] = 1'b1;
    bus_wr(1'b1, 1'b1, 4'h0, 32'h0000_0310);
    chk("R3 edge0 pad_oe", 96'(pad_oe_o), 96'h0000_0010);
    edges(1);
    chk("R3 edge1 pad_oe", 96'(pad_oe_o), 96'h0000_0010);
    edges(1);
    chk("R3/R9/R10 edge2 pad_oe", 96'(pad_oe_o), 96'h0000_0004);
    chk("R9 pad_out", 96'(pad_out_o), 96'h0000_0004);
    periph_out_i[2] = 1'b0;
    #1;
    chk("R9 follow pad_out", 96'(pad_out_o), 96'h0);

    // R9 R10 peripheral input routing
    @(negedge clk_i);
    pad_in_i = 32'h0000_0014;
    edges(2);
    chk("R9/R10 periph_in", periph_in_o, 96'h4);

    // R11 synchronizer delay
    pad_in_i = 32'h5A5A_0001;
    edges(1);
    bus_rd(1'b1, 4'h8, rd); chk("R11 dat edge1", 96'(rd), 96'h0000_0014);
    edges(1);
    bus_rd(1'b1, 4'h8, rd); chk("R11 dat edge2", 96'(rd), 96'h5A5A_0001);

    // R4 protected select write
    bus_wr(1'b0, 1'b1, 4'h0, 32'h0);
    edges(3);
    chk("R4 pad_oe", 96'(pad_oe_o), 96'h0000_0004);
    bus_rd(1'b1, 4'h0, rd); chk("R4 fsel_lo", 96'(rd), 96'h0000_0310);

    // R2 upper select register: pin16 -> fn2
    periph_oe_i[48] = 1'b1; periph_out_i[48] = 1'b1;
    bus_wr(1'b1, 1'b1, 4'h2, 32'h0000_0002);
    edges(2);
    chk("R2 pad_oe", 96'(pad_oe_o), 96'h0001_0004);
    chk("R2 pad_out", 96'(pad_out_o), 96'h0001_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule